// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block lets a 16-bit core reach slow external memories and peripherals over one shared address/data bus. A core request, taken only while the sequencer is idle, becomes a bus cycle with three parts. First an address phase drives the address while the latch strobe pulses. Then a hold clock keeps the address on the bus. Last comes a data phase with either the read strobe or the write strobe active. The core sees a one-clock acknowledge when the data phase ends. During wait-state clocks a stall output holds the core idle.

A small control register holds two settings. The first is a 4-bit wait field with inverted sense: the number of added clocks is 15 minus the field, so the reset value of 0 gives the slowest bus. The second is a one-bit release-gap flag. When it is set, every read is followed by one idle clock. This gives the external device time to stop driving the bus before the next address phase. Both settings are captured when a request is taken, so a later register write does not change a cycle that is already running.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset all strobes, the bus output enable, ack_o and stall_o are low, the wait field is 0 (15 wait clocks) and the release gap is off.
- R2: A cycle starts with exactly one clock of ale_o with the address on ad_o and ad_oe_o high. One hold clock follows with the same address, ale_o low and no strobe. At most one of ale_o, rd_o and wr_o is high in any clock.
- R3: The strobe phase lasts 1 + (15 - F) clocks, where F is the 4-bit wait field. rd_o is high when we_i was 0 at acceptance and wr_o when it was 1.
- R4: During a write strobe, ad_o carries the write data with ad_oe_o high. During a read strobe, ad_oe_o is low.
- R5: Read data is ad_i as sampled at the end of the last read strobe clock, and it appears on rdata_o in the clock where ack_o is high.
- R6: ack_o is high for exactly one clock, the clock right after the last strobe clock.
- R7: stall_o is high in every strobe clock except the last, and low at all other times.
- R8: With the gap flag set, one clock with no strobe and a released bus follows each read, and no request is taken in that clock. Writes never get a gap, and with the flag clear reads get none.
- R9: A request is taken only while idle, which includes the ack clock when there is no gap. The wait field and gap flag in force at acceptance apply to the whole cycle. A control write in the accepting clock affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | DW | Access address |
| wdata_i | input | DW | Write data |
| ack_o | output | 1 | One-clock end-of-access pulse |
| rdata_o | output | DW | Read data, valid with ack_o |
| stall_o | output | 1 | Core hold during wait clocks |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wait_i | input | WFW | Wait field, waits = 15 - value |
| cfg_gap_i | input | 1 | Release gap after reads |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| ad_o | output | DW | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | DW | Shared bus input value |

## Verification
Two things can happen in the same clock: a control register write and the acceptance of a request. The bench provokes this by raising cfg_we_i with new settings in the same clock as req_i. It then checks that the strobe length and gap of that access follow the old settings, and that the next access follows the new ones. A second overlap is the ack clock of one access taking the next request. This is provoked by holding req_i high across back-to-back reads and writes, and the bench checks that the new latch strobe starts exactly one clock after the ack, or two clocks after it when a gap applies. The bench device changes ad_i on every read strobe clock, so a sample taken in the wrong clock shows up as wrong data.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LATCH,
    PH_HOLD,
    PH_STROBE,
    PH_GAP
  } phase_e;
endpackage

// File: rtl/mbs_cfg_reg.sv
module mbs_cfg_reg #(
  parameter int WFW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [WFW-1:0] wait_i,
  input  logic           gap_i,
  output logic [WFW-1:0] wait_o,
  output logic           gap_o
);
  // reset value 0 selects the longest cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_o <= '0;
      gap_o  <= 1'b0;
    end else if (we_i) begin
      wait_o <= wait_i;
      gap_o  <= gap_i;
    end
  end
endmodule

// File: rtl/mbs_wait_ctr.sv
module mbs_wait_ctr #(
  parameter int WFW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [WFW-1:0] fld_i,
  input  logic           dec_i,
  output logic           zero_o
);
  localparam logic [WFW-1:0] MaxWait = '1;

  logic [WFW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= MaxWait - fld_i;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  wait_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  input  logic   gap_en_i,
  input  logic   zero_i,
  output logic   accept_o,
  output logic   dec_o,
  output logic   ack_o,
  output logic   stall_o,
  output logic   we_o,
  output phase_e ph_o
);
  phase_e ph_q, ph_d;
  logic   we_q, gap_q, ack_q;

  assign accept_o = (ph_q == PH_IDLE) && req_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (req_i) ph_d = PH_LATCH;
      PH_LATCH:  ph_d = PH_HOLD;
      PH_HOLD:   ph_d = PH_STROBE;
      PH_STROBE: if (zero_i) ph_d = (gap_q && !we_q) ? PH_GAP : PH_IDLE;
      PH_GAP:    ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      we_q  <= 1'b0;
      gap_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ack_q <= (ph_q == PH_STROBE) && zero_i;
      if (accept_o) begin
        we_q  <= we_i;
        gap_q <= gap_en_i;
      end
    end
  end

  assign dec_o   = (ph_q == PH_STROBE);
  assign stall_o = (ph_q == PH_STROBE) && !zero_i;
  assign ack_o   = ack_q;
  assign we_o    = we_q;
  assign ph_o    = ph_q;

  // R8
  gap_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_GAP) |=> (ph_q == PH_IDLE));
  // R9
  busy_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ph_q != PH_IDLE) |=> (ph_q != PH_LATCH));
endmodule

// File: rtl/mbs_bus_drv.sv
module mbs_bus_drv
  import mbs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  phase_e        ph_i,
  input  logic          we_i,
  input  logic          sample_i,
  input  logic [DW-1:0] ad_i,
  output logic          ale_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic          addr_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (sample_i && !we_i) rdata_q <= ad_i;
    end
  end

  assign addr_ph = (ph_i == PH_LATCH) || (ph_i == PH_HOLD);
  assign ale_o   = (ph_i == PH_LATCH);
  assign rd_o    = (ph_i == PH_STROBE) && !we_i;
  assign wr_o    = (ph_i == PH_STROBE) && we_i;
  assign ad_oe_o = addr_ph || wr_o;
  assign ad_o    = addr_ph ? addr_q : (wr_o ? wdata_q : '0);
  assign rdata_o = rdata_q;

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ale_o, rd_o, wr_o}));
  // R2
  hold_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && ad_oe_o && !rd_o && !wr_o && ad_o == $past(ad_o)));
  // R4
  read_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !ad_oe_o);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int DW  = 16,
  parameter int WFW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [DW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           ack_o,
  output logic [DW-1:0]  rdata_o,
  output logic           stall_o,
  input  logic           cfg_we_i,
  input  logic [WFW-1:0] cfg_wait_i,
  input  logic           cfg_gap_i,
  output logic           ale_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe_o,
  input  logic [DW-1:0]  ad_i
);
  logic [WFW-1:0] wait_fld;
  logic           gap_en, accept, dec, zero, we_cur;
  phase_e         ph;

  mbs_cfg_reg #(.WFW(WFW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wait_i(cfg_wait_i), .gap_i(cfg_gap_i),
    .wait_o(wait_fld), .gap_o(gap_en)
  );

  mbs_wait_ctr #(.WFW(WFW)) u_wait (
    .clk_i, .rst_ni,
    .load_i(accept), .fld_i(wait_fld), .dec_i(dec), .zero_o(zero)
  );

  mbs_fsm u_fsm (
    .clk_i, .rst_ni,
    .req_i, .we_i, .gap_en_i(gap_en), .zero_i(zero),
    .accept_o(accept), .dec_o(dec), .ack_o, .stall_o,
    .we_o(we_cur), .ph_o(ph)
  );

  mbs_bus_drv #(.DW(DW)) u_drv (
    .clk_i, .rst_ni,
    .accept_i(accept), .addr_i, .wdata_i,
    .ph_i(ph), .we_i(we_cur), .sample_i(dec && zero), .ad_i,
    .ale_o, .rd_o, .wr_o, .ad_o, .ad_oe_o, .rdata_o
  );

  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R7
  stall_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (rd_o || wr_o));
  // R6
  ack_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && !stall_o) |=> (ack_o && !rd_o && !wr_o));
endmodule

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, cfg_we = 0, cfg_gap = 0;
  logic [15:0] addr = 0, wdata = 0, ad_in = 16'hdead;
  logic [3:0]  cfg_wait = 0;
  logic        ack, stall, ale, rd, wr, oe;
  logic [15:0] rdata, ad_out;

  int checks = 0, errors = 0, wd = 0;

  always #2 clk = ~clk;

  mux_bus_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .stall_o(stall),
    .cfg_we_i(cfg_we), .cfg_wait_i(cfg_wait), .cfg_gap_i(cfg_gap),
    .ale_o(ale), .rd_o(rd), .wr_o(wr), .ad_o(ad_out), .ad_oe_o(oe), .ad_i(ad_in)
  );

  // behavioural model state
  bit          m_busy, m_w, m_gap, m_ack, m_took;
  int          m_c, m_nw;
  logic [15:0] m_addr, m_wd, m_exp_rd;
  logic [3:0]  c_fld;
  bit          c_gap;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ack = 0; m_took = 0; m_c = 0; m_nw = 15; m_w = 0; m_gap = 0;
      c_fld = 0; c_gap = 0; m_exp_rd = 0;
    end else begin
      bit strobe, last;
      strobe = m_busy && m_c >= 3 && m_c <= 3 + m_nw;
      last   = strobe && m_c == 3 + m_nw;
      if (last && !m_w) m_exp_rd = m_addr ^ 16'(m_nw * 16'h1111);
      m_took = 0;
      if (m_busy) begin
        m_c++;
        if (m_c == 4 + m_nw && !(m_gap && !m_w)) m_busy = 0;
        else if (m_c == 5 + m_nw) m_busy = 0;
      end else if (req) begin
        m_busy = 1; m_c = 1; m_w = we; m_addr = addr; m_wd = wdata;
        m_nw = 15 - int'(c_fld); m_gap = c_gap; m_took = 1;
      end
      m_ack = last;
      if (cfg_we) begin c_fld = cfg_wait; c_gap = cfg_gap; end
    end
  end

  // external device: value changes every read strobe clock
  int rd_cnt = 0;
  logic [15:0] lat_addr = 0;
  always @(negedge clk) begin
    if (ale) lat_addr = ad_out;
    if (rd) begin
      ad_in = lat_addr ^ 16'(rd_cnt * 16'h1111);
      rd_cnt++;
    end else begin
      ad_in = 16'hdead;
      rd_cnt = 0;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_strobe, e_gap, e_oe;
      e_strobe = m_busy && m_c >= 3 && m_c <= 3 + m_nw;
      e_gap    = m_busy && m_c == 4 + m_nw;
      e_oe     = m_busy && (m_c == 1 || m_c == 2 || (e_strobe && m_w));
      chk((m_busy && m_c == 1) ? "R9 ale start" : "R2 ale", 16'(ale), 16'(m_busy && m_c == 1));
      chk("R3 rd", 16'(rd), 16'(e_strobe && !m_w));
      chk("R3 wr", 16'(wr), 16'(e_strobe && m_w));
      chk("R4 oe", 16'(oe), 16'(e_oe));
      if (e_oe) chk((m_c <= 2) ? "R2 addr" : "R4 wdata", ad_out, (m_c <= 2) ? m_addr : m_wd);
      chk("R7 stall", 16'(stall), 16'(e_strobe && m_c < 3 + m_nw));
      chk("R6 ack", 16'(ack), 16'(m_ack));
      if (m_ack && !m_w) chk("R5 rdata", rdata, m_exp_rd);
      if (e_gap) chk("R8 gap quiet", 16'({ale, rd, wr, oe}), 16'h0);
    end
  end

  task automatic issue(bit w, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!m_took);
    req = 0;
  endtask

  task automatic drain();
    do @(negedge clk); while (m_busy || m_ack);
  endtask

  task automatic set_cfg(logic [3:0] f, bit g);
    @(negedge clk);
    cfg_we = 1; cfg_wait = f; cfg_gap = g;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 strobes", 16'({ale, rd, wr, oe, ack, stall}), 16'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", 16'({ale, rd, wr, oe, ack, stall}), 16'h0);
    // R1 default: 15 waits
    issue(0, 16'h1234, 16'h0); drain();
    issue(1, 16'h00f0, 16'hbeef); drain();
    // R3 zero waits, back-to-back with req held
    set_cfg(4'hf, 0);
    @(negedge clk); req = 1; we = 0; addr = 16'h4000;
    do @(negedge clk); while (!m_took);
    we = 1; addr = 16'h4002; wdata = 16'h5a5a;
    do @(negedge clk); while (!m_took);
    we = 0; addr = 16'h4004;
    do @(negedge clk); while (!m_took);
    req = 0; drain();
    // R8 gap on reads, back-to-back
    set_cfg(4'hc, 1);
    @(negedge clk); req = 1; we = 0; addr = 16'h8001;
    do @(negedge clk); while (!m_took);
    addr = 16'h8003;
    do @(negedge clk); while (!m_took);
    we = 1; wdata = 16'h1357; addr = 16'h8005;
    do @(negedge clk); while (!m_took);
    we = 0; addr = 16'h8007;
    do @(negedge clk); while (!m_took);
    req = 0; drain();
    // R9 config write in the accepting clock
    set_cfg(4'he, 0);
    @(negedge clk);
    req = 1; we = 0; addr = 16'hc0de; cfg_we = 1; cfg_wait = 4'h9; cfg_gap = 1;
    @(negedge clk); cfg_we = 0;
    while (!m_took) @(negedge clk);
    req = 0; drain();
    issue(0, 16'hface, 16'h0); drain();
    issue(1, 16'h0bad, 16'hcafe); drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule